// File: doc/BRIEF.md
# Quarter-Wave Quadrature Sine/Cosine Oscillator

This block is a numerically controlled oscillator. Every clock it produces one sine sample and one cosine sample of the same phase. A 32-bit tuning word is added to a 32-bit phase register on each clock, and the register wraps modulo 2^32. The output frequency is therefore tune × Fclk / 2^32, and it is usable up to just below Fclk/2.

Only the top 12 phase bits are used. The upper two of them give the quadrant and the lower ten give the position within that quadrant. A single table holds non-negative magnitudes for the first quarter period. The block computes this table at elaboration. Both outputs read it through two read ports. Depending on the quadrant, each output reads the table with the address counting up or mirrored, and then applies its own sign rule. This rebuilds full-period signed samples.

The outputs form a continuous stream with no back-pressure: a new sample leaves every clock and cannot be stalled. `smp_valid` marks the samples whose phase was produced after the last clear. The sample for a given phase leaves three clocks after that phase sits in the phase register.

Top module: `nco_quad_sincos`

## Requirements
- R1: On each clock with `clr` low, the phase register takes the value phase + `tune` modulo 2^32. The register is internal and is seen only through the outputs.
- R2: The lookup phase P is bits 31:20 of the phase register. Bits 19:0 have no effect on the outputs. With `tune` = 1 after a clear, the outputs stay at sine 2 and cosine 2047.
- R3: The quadrant is P[11:10], and the in-quadrant address is a = P[9:0]. Sine reads entry a in quadrants 0 and 2 and entry ~a in quadrants 1 and 3. Sine is positive in quadrants 0 and 1 and negated in quadrants 2 and 3. The result is within ±1 of round(2047·sin(2π(P+0.5)/4096)).
- R4: Cosine reads entry ~a in quadrants 0 and 2 and entry a in quadrants 1 and 3. Cosine is negated in quadrants 1 and 2 only. The result is within ±1 of round(2047·cos(2π(P+0.5)/4096)).
- R5: Table entry k holds round(2047·sin((2k+1)π/4096)), which is capped at 2047. A two's-complement output of 12 bits therefore never takes the value -2048.
- R6: The outputs produced from the phase held after clock edge j appear after edge j+3. `smp_valid` is high exactly when a sample comes from a phase formed after the last clear, which is from the third edge after a clear onward.
- R7: A clock edge with `clr` high sets the phase to 0, sets both outputs to 0 and sets `smp_valid` low.
- R8: With `tune` = 269591793, the sine output completes between 62 and 63 rising zero crossings in 1000 consecutive valid samples, which is a period of about 15.9 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clr | input | 1 | Synchronous clear of the phase and the pipeline |
| tune | input | 32 | Phase increment per clock |
| smp_valid | output | 1 | Current sample derives from a phase formed after the last clear |
| sin_out | output | 12 | Sine sample, two's complement |
| cos_out | output | 12 | Cosine sample, two's complement |

## Verification
The bench aims at the quadrant seams, where mirrored addressing is easiest to get wrong:

- **Mirroring off by one entry.** A design that mirrors with 1024−a instead of the bitwise inverse would read past the table or repeat a sample. Per-sample comparison against the real-valued reference catches this.
- **Swapped or wrong sign rule.** A design that used the sine sign rule for cosine would flip cosine in quadrant 3. The same comparison catches this.
- **Wrap and truncation.** Wrap is exercised with an all-ones tuning word. Truncation is exercised with a tuning word of 1, which must leave the outputs frozen.
- **Latency and valid timing.** A wrong pipeline depth would misalign every sample against the bench model of the phase, and a wrong valid timing would show up at the edges around a clear.
- **Wrong frequency.** The directed tuning word is checked by counting zero crossings.

// File: rtl/nco_pkg.sv
package nco_pkg;

  typedef enum logic [1:0] {
    Q_RISE     = 2'd0,
    Q_FALL     = 2'd1,
    Q_NEG_FALL = 2'd2,
    Q_NEG_RISE = 2'd3
  } quad_e;

  localparam longint PI_Q30 = 64'sd3373259426;

  // Quarter-wave magnitude at the midpoint of entry k, integer Taylor series in Q30.
  function automatic int quarter_mag(input int k, input int depth, input int amp);
    longint x;
    longint term;
    longint sum;
    longint mag;
    x = ((2 * longint'(k) + 1) * PI_Q30) / (4 * longint'(depth));
    term = x;
    sum = x;
    for (int n = 1; n < 10; n++) begin
      term = ((((term * x) >>> 30) * x) >>> 30);
      term = -(term / (longint'(2 * n) * longint'(2 * n + 1)));
      sum = sum + term;
    end
    mag = (sum * longint'(amp) + (64'sd1 <<< 29)) >>> 30;
    if (mag > longint'(amp)) mag = longint'(amp);
    if (mag < 0) mag = 0;
    return int'(mag);
  endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [ACC_W-1:0] tune,
  output logic [ACC_W-1:0] phase
);

  always_ff @(posedge clk) begin
    if (clr) phase <= '0;
    else     phase <= phase + tune;
  end

  p_acc_step_r1: assert property (@(posedge clk) disable iff (clr)
    !clr |=> phase == $past(phase + tune));

  p_clear_zero_r7: assert property (@(posedge clk)
    clr |=> phase == '0);

endmodule

// File: rtl/nco_quad_map.sv
module nco_quad_map
  import nco_pkg::*;
#(
  parameter int PHASE_W = 12,
  localparam int ADDR_W = PHASE_W - 2
) (
  input  logic               clk,
  input  logic               clr,
  input  logic [PHASE_W-1:0] phase_top,
  output logic [ADDR_W-1:0]  sin_addr,
  output logic [ADDR_W-1:0]  cos_addr,
  output logic               sin_neg,
  output logic               cos_neg,
  output quad_e              quad
);

  quad_e             q_c;
  logic [ADDR_W-1:0] a_c;
  logic [ADDR_W-1:0] sin_addr_c, cos_addr_c;
  logic              sin_neg_c, cos_neg_c;

  assign q_c = quad_e'(phase_top[PHASE_W-1 -: 2]);
  assign a_c = phase_top[ADDR_W-1:0];

  always_comb begin
    unique case (q_c)
      Q_RISE:     begin sin_addr_c = a_c;  cos_addr_c = ~a_c; sin_neg_c = 1'b0; cos_neg_c = 1'b0; end
      Q_FALL:     begin sin_addr_c = ~a_c; cos_addr_c = a_c;  sin_neg_c = 1'b0; cos_neg_c = 1'b1; end
      Q_NEG_FALL: begin sin_addr_c = a_c;  cos_addr_c = ~a_c; sin_neg_c = 1'b1; cos_neg_c = 1'b1; end
      default:    begin sin_addr_c = ~a_c; cos_addr_c = a_c;  sin_neg_c = 1'b1; cos_neg_c = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      sin_addr <= '0;
      cos_addr <= '0;
      sin_neg  <= 1'b0;
      cos_neg  <= 1'b0;
      quad     <= Q_RISE;
    end else begin
      sin_addr <= sin_addr_c;
      cos_addr <= cos_addr_c;
      sin_neg  <= sin_neg_c;
      cos_neg  <= cos_neg_c;
      quad     <= q_c;
    end
  end

  // R3/R4: the two outputs always read complementary addresses once running
  p_addr_pair_r3: assert property (@(posedge clk) disable iff (clr)
    !clr |=> sin_addr == ~cos_addr);

endmodule

// File: rtl/nco_quarter_rom.sv
module nco_quarter_rom
  import nco_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int MAG_W  = 11,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int AMP   = (1 << MAG_W) - 1
) (
  input  logic              clk,
  input  logic              clr,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  output logic [MAG_W-1:0]  mag_a,
  output logic [MAG_W-1:0]  mag_b
);

  logic [MAG_W-1:0] tbl [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_ent
    localparam int V = quarter_mag(k, DEPTH, AMP);
    assign tbl[k] = MAG_W'(V);
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      mag_a <= '0;
      mag_b <= '0;
    end else begin
      mag_a <= tbl[addr_a];
      mag_b <= tbl[addr_b];
    end
  end

endmodule

// File: rtl/nco_quad_sincos.sv
module nco_quad_sincos
  import nco_pkg::*;
#(
  parameter int ACC_W   = 32,
  parameter int PHASE_W = 12,
  parameter int OUT_W   = 12
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [ACC_W-1:0] tune,
  output logic             smp_valid,
  output logic [OUT_W-1:0] sin_out,
  output logic [OUT_W-1:0] cos_out
);

  localparam int ADDR_W = PHASE_W - 2;
  localparam int MAG_W  = OUT_W - 1;
  localparam int LAT    = 3;

  logic [ACC_W-1:0]  phase;
  logic [ADDR_W-1:0] sin_addr, cos_addr;
  logic              sin_neg, cos_neg;
  logic              sin_neg_d, cos_neg_d;
  quad_e             quad;
  logic [MAG_W-1:0]  sin_mag, cos_mag;
  logic [LAT-1:0]    vld_sr;
  logic [OUT_W-1:0]  sin_ext, cos_ext;

  nco_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .clr(clr), .tune(tune), .phase(phase)
  );

  nco_quad_map #(.PHASE_W(PHASE_W)) u_map (
    .clk(clk), .clr(clr), .phase_top(phase[ACC_W-1 -: PHASE_W]),
    .sin_addr(sin_addr), .cos_addr(cos_addr),
    .sin_neg(sin_neg), .cos_neg(cos_neg), .quad(quad)
  );

  nco_quarter_rom #(.ADDR_W(ADDR_W), .MAG_W(MAG_W)) u_rom (
    .clk(clk), .clr(clr), .addr_a(sin_addr), .addr_b(cos_addr),
    .mag_a(sin_mag), .mag_b(cos_mag)
  );

  assign sin_ext = {1'b0, sin_mag};
  assign cos_ext = {1'b0, cos_mag};

  always_ff @(posedge clk) begin
    if (clr) begin
      sin_neg_d <= 1'b0;
      cos_neg_d <= 1'b0;
      sin_out   <= '0;
      cos_out   <= '0;
      vld_sr    <= '0;
    end else begin
      sin_neg_d <= sin_neg;
      cos_neg_d <= cos_neg;
      sin_out   <= sin_neg_d ? (~sin_ext + 1'b1) : sin_ext;
      cos_out   <= cos_neg_d ? (~cos_ext + 1'b1) : cos_ext;
      vld_sr    <= {vld_sr[LAT-2:0], 1'b1};
    end
  end

  assign smp_valid = vld_sr[LAT-1];

  p_sin_sign_r3: assert property (@(posedge clk) disable iff (clr)
    (quad == Q_RISE || quad == Q_FALL) |-> ##2 $signed(sin_out) >= 0);

  p_cos_sign_r4: assert property (@(posedge clk) disable iff (clr)
    (quad == Q_FALL || quad == Q_NEG_FALL) |-> ##2 $signed(cos_out) <= 0);

  p_no_min_r5: assert property (@(posedge clk) disable iff (clr)
    smp_valid |-> (sin_out != {1'b1, {(OUT_W-1){1'b0}}}) && (cos_out != {1'b1, {(OUT_W-1){1'b0}}}));

  p_valid_drop_r6: assert property (@(posedge clk)
    clr |=> !smp_valid && sin_out == '0 && cos_out == '0);

endmodule

// File: tb/tb_nco_quad_sincos.sv
module tb_nco_quad_sincos;

  localparam real PI = 3.14159265358979323846;

  logic        clk = 1'b0;
  logic        clr = 1'b1;
  logic [31:0] tune = '0;
  logic        smp_valid;
  logic [11:0] sin_out, cos_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  string ctx = "init";

  always #5 clk = ~clk;

  nco_quad_sincos dut (
    .clk(clk), .clr(clr), .tune(tune),
    .smp_valid(smp_valid), .sin_out(sin_out), .cos_out(cos_out)
  );

  // Bench model of the phase (R1) and of the three-edge latency (R6)
  logic [31:0] m_acc, h1, h2, h3;
  int vcnt = 0;
  always @(posedge clk) begin
    m_acc <= clr ? 32'd0 : m_acc + tune;
    h1 <= m_acc;
    h2 <= h1;
    h3 <= h2;
    if (clr) vcnt <= 0;
    else if (vcnt < 3) vcnt <= vcnt + 1;
  end

  function automatic int ref_val(input logic [11:0] p, input bit is_cos);
    real a, r;
    a = 2.0 * PI * (real'(p) + 0.5) / 4096.0;
    r = 2047.0 * (is_cos ? $cos(a) : $sin(a));
    return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
  endfunction

  task automatic check(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s [%s] got=%0d expected=%0d at %0t", req, ctx, got, exp, $time);
    end
  endtask

  // Continuous per-sample checks
  always @(negedge clk) begin
    if (!done) begin
      check(smp_valid == (vcnt == 3), "R6 valid", int'(smp_valid), int'(vcnt == 3));
      if (vcnt == 3) begin
        int es, ec, gs, gc;
        es = ref_val(h3[31:20], 1'b0);
        ec = ref_val(h3[31:20], 1'b1);
        gs = int'($signed(sin_out));
        gc = int'($signed(cos_out));
        check(gs - es <= 1 && es - gs <= 1, "R3 sine", gs, es);
        check(gc - ec <= 1 && ec - gc <= 1, "R4 cosine", gc, ec);
        check(gs != -2048 && gc != -2048, "R5 range", (gs < gc) ? gs : gc, -2047);
      end
    end
  end

  task automatic do_clear(input int n);
    @(negedge clk); clr = 1'b1;
    repeat (n) @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd24681));
    // R7: clear state
    ctx = "reset";
    tune = 32'h1234_5678;
    clr = 1'b1;
    repeat (3) @(negedge clk);
    check(sin_out == 12'd0 && cos_out == 12'd0, "R7 outputs zero", int'(sin_out), 0);
    check(smp_valid == 1'b0, "R7 valid low", int'(smp_valid), 0);

    // R6: valid rises on third edge after clear release
    clr = 1'b0;
    @(negedge clk); check(!smp_valid, "R6 fill 1", int'(smp_valid), 0);
    @(negedge clk); check(!smp_valid, "R6 fill 2", int'(smp_valid), 0);
    @(negedge clk); check(smp_valid,  "R6 fill 3", int'(smp_valid), 1);
    repeat (50) @(negedge clk);

    // R7: clear in the middle of a run
    ctx = "mid clear";
    @(negedge clk); clr = 1'b1;
    @(negedge clk);
    check(sin_out == 12'd0 && cos_out == 12'd0 && !smp_valid, "R7 mid clear", int'(sin_out), 0);
    clr = 1'b0;

    // R2: low phase bits alone never move the outputs
    ctx = "R2 tune=1";
    tune = 32'd1;
    do_clear(1);
    repeat (40) begin
      @(negedge clk);
      if (smp_valid) begin
        check(int'($signed(sin_out)) == 2,    "R2 sine frozen",   int'($signed(sin_out)), 2);
        check(int'($signed(cos_out)) == 2047, "R2 cosine frozen", int'($signed(cos_out)), 2047);
      end
    end

    // R1: wrap with all-ones word (phase steps backward)
    ctx = "R1 wrap";
    tune = 32'hFFFF_FFFF;
    do_clear(1);
    repeat (30) @(negedge clk);
    tune = 32'hFFF0_0000;
    repeat (300) @(negedge clk);

    // Quadrant seams: quarter-period and Nyquist steps
    ctx = "quarter steps";
    tune = 32'h4000_0000;
    do_clear(1);
    repeat (20) @(negedge clk);
    ctx = "nyquist";
    tune = 32'h8000_0000;
    repeat (20) @(negedge clk);
    ctx = "fine sweep";
    tune = 32'h0010_0000;
    repeat (4200) @(negedge clk);

    // R8: directed word, count rising zero crossings
    ctx = "R8 directed";
    tune = 32'd269591793;
    do_clear(1);
    repeat (3) @(negedge clk);
    begin
      int xings = 0;
      int prev = int'($signed(sin_out));
      for (int i = 0; i < 1000; i++) begin
        @(negedge clk);
        if (prev < 0 && int'($signed(sin_out)) >= 0) xings++;
        prev = int'($signed(sin_out));
      end
      check(xings >= 62 && xings <= 63, "R8 period", xings, 63);
    end

    // Constrained random words with occasional clears
    ctx = "random";
    for (int seg = 0; seg < 40; seg++) begin
      case ($urandom % 4)
        0: tune = $urandom;
        1: tune = $urandom % 32'h0100_0000;
        2: tune = 32'h8000_0000 - ($urandom % 32'h0010_0000);
        default: tune = {$urandom % 4, 30'd0} + ($urandom % 32'h0000_1000);
      endcase
      if ($urandom % 3 == 0) do_clear(1 + ($urandom % 3));
      repeat (150 + ($urandom % 100)) @(negedge clk);
    end

    finish_run();
  end

endmodule